// File: doc/BRIEF.md
# Vector Pack/Unpack Offset Sequencer

This block drives a vector move that reorders subvectors. It does not touch any data. For every element pair of the move, it produces a source offset and a destination offset, and a consumer moves the data between them. The caller sets a vector length VL (0 to 64) and a subvector length S (1 to 4). A single iteration walks through pair k = 0 .. VL*S-1, and for each pair it forms an element index i = k / S and a subvector index j = k mod S.

Each side can use one of two offset layouts, and the two sides choose independently:

- **Element layout.** The components of each element are placed next to each other: offset = i*S + j.
- **Planar layout.** Component j of every element forms a contiguous plane: offset = i + VL*j.

A two-bit mode selector picks the layout for each side. Element source with planar destination scatters interleaved data into planes (unpack). Planar source with element destination gathers planes into interleaved data (pack).

A one-cycle start pulse latches the configuration and begins a run. The consumer takes one pair per cycle with a valid/ready handshake. A done flag marks the final pair. The offsets are built from running accumulators, so the block needs no multiplier.

Top module: `vec_reorder_seq`

## Requirements
- R1: In element layout, pair k gets the offset i*S + j, which equals k.
- R2: In planar layout, pair k gets the offset i + VL*j, where i = k / S and j = k mod S.
- R3: Bit 0 of `modeSel` (the pack enable) selects planar layout for the source offset. When the bit is clear, the source uses element layout.
- R4: Bit 1 of `modeSel` (the unpack enable) selects planar layout for the destination offset. When the bit is clear, the destination uses element layout.
- R5: When both mode bits are clear, or both are set, the source and destination offsets are equal for every pair.
- R6: The `subLenM1` field encodes S as field value + 1, so 0 means S=1 and 3 means S=4.
- R7: A run that starts with VL > 0 produces exactly VL*S pairs. Valid rises in the cycle after the start is accepted. Done is high only together with the last pair. Valid is low after the last pair is accepted.
- R8: A start with VL = 0 produces no valid pair. It raises done for exactly one cycle, in the cycle after the start.
- R9: While valid is high and ready is low, both offsets and valid hold unchanged.
- R10: While a run is in progress, a start pulse and any change on the configuration inputs have no effect on the pairs produced.
- R11: During and straight after reset, valid and done are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| seqStart | input | 1 | Start pulse, accepted only when idle |
| vecLen | input | 7 | Vector length VL, 0 to 64 |
| subLenM1 | input | 2 | Subvector length minus one |
| modeSel | input | 2 | Bit 0: source planar (pack); bit 1: destination planar (unpack) |
| pairReady | input | 1 | Consumer takes the current pair |
| srcOfs | output | 8 | Source element offset |
| dstOfs | output | 8 | Destination element offset |
| pairValid | output | 1 | A pair is presented |
| seqDone | output | 1 | Last pair, or the empty-run pulse |

## Verification
The first pair appears one clock edge after the start is sampled. Each later pair appears one edge after an accepted handshake. The empty-run done pulse is due one edge after the start and is gone after the edge that follows.

The bench drives inputs and samples outputs on falling edges. The values it reads were therefore produced by the rising edge just before. It checks every pair at the falling edge where that pair is current.

During a stalled cycle the bench re-checks the same pair index, which confirms that nothing moved. After the last handshake it checks one more falling edge to confirm that valid and done have dropped.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_EMPTY = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch configuration, clear walkers
    logic step;    // handshake accepted, advance one pair
    logic rowEnd;  // current pair is the last component of its element
  } seqStrobe_t;

  // positions inside the mode selector
  localparam int MODE_PACK_BIT   = 0;
  localparam int MODE_UNPACK_BIT = 1;

endpackage

// File: rtl/vrs_offset_walker.sv
module vrs_offset_walker
  import vrs_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int SUB_W = 2,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             planar,
  input  logic [VL_W-1:0]  cfgVl,
  input  logic [SUB_W-1:0] cfgSubM1,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] ofsQ;
  logic [OFS_W-1:0] rowBaseQ;
  logic [OFS_W-1:0] stride;
  logic [OFS_W-1:0] rowInc;
  logic [OFS_W-1:0] nextBase;

  // Within an element, planar moves by VL and element layout by 1.
  // At an element boundary, the row base moves by 1 (planar) or by S (element).
  always_comb begin
    stride   = planar ? OFS_W'(cfgVl) : OFS_W'(1);
    rowInc   = planar ? OFS_W'(1) : (OFS_W'(cfgSubM1) + OFS_W'(1));
    nextBase = rowBaseQ + rowInc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsQ     <= '0;
      rowBaseQ <= '0;
    end else if (strobe.load) begin
      ofsQ     <= '0;
      rowBaseQ <= '0;
    end else if (strobe.step) begin
      if (strobe.rowEnd) begin
        rowBaseQ <= nextBase;
        ofsQ     <= nextBase;
      end else begin
        ofsQ     <= ofsQ + stride;
      end
    end
  end

  assign ofs = ofsQ;

  AST_ELEM_UNIT_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !planar) |=> (ofs == OFS_W'($past(ofs) + OFS_W'(1)))); // R1

  AST_PLANAR_VL_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && planar && !strobe.rowEnd) |=>
      (ofs == OFS_W'($past(ofs) + OFS_W'($past(cfgVl))))); // R2

endmodule

// File: rtl/vrs_datapath.sv
module vrs_datapath
  import vrs_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int SUB_W = 2,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [SUB_W-1:0] subLenM1,
  input  logic [1:0]       modeSel,
  output logic [VL_W-1:0]  cfgVl,
  output logic [SUB_W-1:0] cfgSubM1,
  output logic             cfgPack,
  output logic             cfgUnpack,
  output logic [OFS_W-1:0] srcOfs,
  output logic [OFS_W-1:0] dstOfs
);

  logic [VL_W-1:0]  vlQ;
  logic [SUB_W-1:0] subM1Q;
  logic [1:0]       modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlQ    <= '0;
      subM1Q <= '0;
      modeQ  <= '0;
    end else if (strobe.load) begin
      vlQ    <= vecLen;
      subM1Q <= subLenM1;
      modeQ  <= modeSel;
    end
  end

  assign cfgVl     = vlQ;
  assign cfgSubM1  = subM1Q;
  assign cfgPack   = modeQ[MODE_PACK_BIT];
  assign cfgUnpack = modeQ[MODE_UNPACK_BIT];

  // side 0 = source (pack bit), side 1 = destination (unpack bit)
  logic [OFS_W-1:0] sideOfs [2];

  for (genvar g = 0; g < 2; g++) begin : g_side
    vrs_offset_walker #(
      .VL_W  (VL_W),
      .SUB_W (SUB_W),
      .OFS_W (OFS_W)
    ) i_walker (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .planar   (modeQ[g]),
      .cfgVl    (vlQ),
      .cfgSubM1 (subM1Q),
      .ofs      (sideOfs[g])
    );
  end

  assign srcOfs = sideOfs[0];
  assign dstOfs = sideOfs[1];

endmodule

// File: rtl/vrs_control.sv
module vrs_control
  import vrs_pkg::*;
#(
  parameter int VL_W  = 7,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqStart,
  input  logic             pairReady,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [VL_W-1:0]  cfgVl,
  input  logic [SUB_W-1:0] cfgSubM1,
  output seqStrobe_t       strobe,
  output logic             pairValid,
  output logic             seqDone
);

  seqState_e        stateQ, stateD;
  logic [VL_W-1:0]  elemIdxQ;
  logic [SUB_W-1:0] subIdxQ;
  logic             rowEnd;
  logic             lastPair;
  logic             accept;
  logic             step;

  always_comb begin
    rowEnd    = (subIdxQ == cfgSubM1);
    lastPair  = rowEnd && (elemIdxQ == (cfgVl - VL_W'(1)));
    accept    = (stateQ == ST_IDLE) && seqStart;
    pairValid = (stateQ == ST_RUN);
    step      = pairValid && pairReady;
    seqDone   = (stateQ == ST_EMPTY) || (pairValid && lastPair);

    strobe.load   = accept;
    strobe.step   = step;
    strobe.rowEnd = rowEnd;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (seqStart) stateD = (vecLen == '0) ? ST_EMPTY : ST_RUN;
      ST_RUN:   if (step && lastPair) stateD = ST_IDLE;
      ST_EMPTY: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      elemIdxQ <= '0;
      subIdxQ  <= '0;
    end else begin
      stateQ <= stateD;
      if (accept) begin
        elemIdxQ <= '0;
        subIdxQ  <= '0;
      end else if (step) begin
        if (rowEnd) begin
          subIdxQ  <= '0;
          elemIdxQ <= elemIdxQ + VL_W'(1);
        end else begin
          subIdxQ  <= subIdxQ + SUB_W'(1);
        end
      end
    end
  end

  AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ((stateQ == ST_IDLE) && seqStart && (vecLen != '0)) |=> pairValid); // R7

  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && pairValid && pairReady) |=> !pairValid); // R7

  AST_EMPTY_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !pairValid) |=> !seqDone); // R8

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |-> ((elemIdxQ < cfgVl) && (subIdxQ <= cfgSubM1))); // R7

endmodule

// File: rtl/vec_reorder_seq.sv
module vec_reorder_seq
  import vrs_pkg::*;
#(
  parameter  int MAX_VL  = 64,
  parameter  int MAX_SUB = 4,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int SUB_W   = $clog2(MAX_SUB),
  localparam int OFS_W   = $clog2(MAX_VL * MAX_SUB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seqStart,
  input  logic [VL_W-1:0]  vecLen,
  input  logic [SUB_W-1:0] subLenM1,
  input  logic [1:0]       modeSel,
  input  logic             pairReady,
  output logic [OFS_W-1:0] srcOfs,
  output logic [OFS_W-1:0] dstOfs,
  output logic             pairValid,
  output logic             seqDone
);

  seqStrobe_t       strobe;
  logic [VL_W-1:0]  cfgVl;
  logic [SUB_W-1:0] cfgSubM1;
  logic             cfgPack;
  logic             cfgUnpack;

  vrs_control #(
    .VL_W  (VL_W),
    .SUB_W (SUB_W)
  ) i_control (
    .clk       (clk),
    .rstN      (rstN),
    .seqStart  (seqStart),
    .pairReady (pairReady),
    .vecLen    (vecLen),
    .cfgVl     (cfgVl),
    .cfgSubM1  (cfgSubM1),
    .strobe    (strobe),
    .pairValid (pairValid),
    .seqDone   (seqDone)
  );

  vrs_datapath #(
    .VL_W  (VL_W),
    .SUB_W (SUB_W),
    .OFS_W (OFS_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .vecLen    (vecLen),
    .subLenM1  (subLenM1),
    .modeSel   (modeSel),
    .cfgVl     (cfgVl),
    .cfgSubM1  (cfgSubM1),
    .cfgPack   (cfgPack),
    .cfgUnpack (cfgUnpack),
    .srcOfs    (srcOfs),
    .dstOfs    (dstOfs)
  );

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && !pairReady) |=>
      (pairValid && $stable(srcOfs) && $stable(dstOfs))); // R9

  AST_SAME_LAYOUT_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && (cfgPack == cfgUnpack)) |-> (srcOfs == dstOfs)); // R5

endmodule

// File: tb/test_vec_reorder_seq.sv
module test_vec_reorder_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       seqStart = 1'b0;
  logic [6:0] vecLen = '0;
  logic [1:0] subLenM1 = '0;
  logic [1:0] modeSel = '0;
  logic       pairReady = 1'b0;
  logic [7:0] srcOfs, dstOfs;
  logic       pairValid, seqDone;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  vec_reorder_seq i_vec_reorder_seq (
    .clk       (clk),
    .rstN      (rstN),
    .seqStart  (seqStart),
    .vecLen    (vecLen),
    .subLenM1  (subLenM1),
    .modeSel   (modeSel),
    .pairReady (pairReady),
    .srcOfs    (srcOfs),
    .dstOfs    (dstOfs),
    .pairValid (pairValid),
    .seqDone   (seqDone)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expOfs(int k, int vl, int s, bit planar);
    int i = k / s;
    int j = k % s;
    return planar ? (i + vl * j) : k;
  endfunction

  // one run: stallEvery>0 drops ready on every stallEvery-th cycle (R9),
  // poke disturbs start and config inputs mid-run (R10)
  task automatic runSeq(input int vl, input int subM1, input bit pack,
                        input bit unpack, input int stallEvery, input bit poke);
    int s = subM1 + 1;
    int total = vl * s;
    int k = 0;
    int cyc = 0;
    @(negedge clk);
    vecLen = 7'(vl); subLenM1 = 2'(subM1); modeSel = {unpack, pack};
    seqStart = 1'b1; pairReady = 1'b0;
    @(negedge clk);
    seqStart = 1'b0;
    while (k < total) begin
      chk("R7 valid", int'(pairValid), 1);
      chk("R3 src", int'(srcOfs), expOfs(k, vl, s, pack));
      chk("R4 dst", int'(dstOfs), expOfs(k, vl, s, unpack));
      chk("R7 done", int'(seqDone), int'(k == total - 1));
      if (pack == unpack) chk("R5 equal", int'(srcOfs), int'(dstOfs));
      if (poke && cyc == 1) begin
        seqStart = 1'b1; vecLen = 7'd0; subLenM1 = ~subLenM1; modeSel = ~modeSel;
      end else begin
        seqStart = 1'b0;
      end
      pairReady = !(stallEvery > 0 && (cyc % stallEvery) == 0);
      if (pairReady) k++;
      @(negedge clk);
      cyc++;
    end
    seqStart = 1'b0; pairReady = 1'b0;
    chk("R7 valid low after last", int'(pairValid), 0);
    chk("R7 done low after last", int'(seqDone), 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11 valid in reset", int'(pairValid), 0);
    chk("R11 done in reset", int'(seqDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", int'(pairValid), 0);
    chk("R11 done after reset", int'(seqDone), 0);
  endtask

  task automatic testEmpty();
    @(negedge clk);
    vecLen = 7'd0; subLenM1 = 2'd2; seqStart = 1'b1; pairReady = 1'b1;
    @(negedge clk);
    seqStart = 1'b0;
    chk("R8 done pulse", int'(seqDone), 1);
    chk("R8 no valid", int'(pairValid), 0);
    @(negedge clk);
    chk("R8 done single cycle", int'(seqDone), 0);
    chk("R8 still no valid", int'(pairValid), 0);
    pairReady = 1'b0;
  endtask

  initial begin
    #2_000_000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();                   // R11
    runSeq(5, 2, 0, 0, 0, 0);      // R1 R5 R6: straight copy, S=3
    runSeq(4, 3, 1, 0, 0, 0);      // R2 R3: pack, S=4
    runSeq(3, 1, 0, 1, 3, 0);      // R4 R9: unpack with stalls
    runSeq(7, 2, 1, 1, 2, 0);      // R5: both planar, stalled
    testEmpty();                   // R8
    runSeq(64, 0, 1, 0, 0, 0);     // R6: S=1, largest VL
    runSeq(64, 3, 0, 1, 0, 0);     // R2: largest offset 255
    runSeq(6, 1, 1, 0, 0, 1);      // R10: disturbed mid-run
    runSeq(1, 3, 1, 1, 4, 0);      // R7: single element
    runSeq(2, 2, 0, 1, 0, 0);      // back-to-back restart
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule